// File: doc/BRIEF.md
# Stack Bytecode Execution Unit

This block runs short programs of 8-bit bytecodes for a stack machine. It reads each code from an external byte memory through a combinational read port, keeps a register-based operand stack of 32-bit entries, and keeps a small array of 32-bit local variables. Six operations are supported: push a literal byte, push zero, load a local, store a local, add, and return.

A host loads a program at address 0 and pulses `start`. The unit then runs until it executes a return, which raises `done`, or until it meets a fault, which raises `error`. In both cases it halts. The local variables can be read at any time through a debug index, and the result is usually read there once the run has halted.

Top module: `sbx_top`

## Requirements
- R1: After reset, `done` and `error` are 0, `memAddr` is 0 and every local variable reads 0.
- R2: A `start` pulse seen while idle or halted clears the stack, the locals, `done` and `error`, and begins fetching at address 0. A `start` seen while a program is running has no effect on the run.
- R3: Opcode 0x10 pushes the byte at the next address, sign-extended to 32 bits. Execution then continues at the byte after that operand.
- R4: Opcode 0x03 pushes the value 0.
- R5: Opcodes 0x1b and 0x1c push local 1 and local 2. Opcodes 0x3c, 0x3d and 0x3e pop the top entry into local 1, local 2 and local 3.
- R6: Opcode 0x60 pops two entries and pushes their sum modulo 2^32.
- R7: Opcode 0xb1 sets `done` and halts. While halted, `done` and `memAddr` hold until the next `start`.
- R8: The stack holds 8 entries. A push with 8 entries already on the stack sets `error` and halts, with `memAddr` left one past the faulting opcode.
- R9: A store with an empty stack, or an add with fewer than two entries, sets `error` and halts.
- R10: Any opcode outside the supported set sets `error` and halts.
- R11: `dbgData` shows, combinationally, the local variable selected by `dbgIdx`, where `dbgIdx` values 0 to 3 select locals 0 to 3.
- R12: Every instruction takes two clock edges: one to fetch and one to execute. Counting the edge that samples `start` as edge 0, a program of N instructions that ends in return shows `done` after edge 2N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a program run from address 0 |
| memAddr | output | ADDR_W (8) | Bytecode memory address (program counter) |
| memData | input | 8 | Byte read combinationally at `memAddr` |
| done | output | 1 | Return executed; unit halted |
| error | output | 1 | Fault (stack bound or unknown opcode); unit halted |
| dbgIdx | input | 2 | Local variable selector for debug read |
| dbgData | output | DATA_W (32) | Selected local variable |

## Verification
The stack-full fault is the hardest case to reach from the ports. It needs eight pushes to land without any pop in between, and then a ninth push. The stimulus reaches it with a run of nine push-zero codes. The bench then checks that the halt leaves the program counter at the ninth opcode plus one and that `done` stays low. A `start` pulse is also injected partway through a run to show that the run's timing and result are unchanged. Another `start` is given after a finished run to show that the locals read zero on the first edge after it.

// File: rtl/sbx_pkg.sv
`timescale 1ns/1ps
package sbx_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_LOCALS = 4;
  localparam int LIDX_W     = $clog2(NUM_LOCALS);

  typedef enum logic [BYTE_W-1:0] {
    OP_PUSH_BYTE = 8'h10,
    OP_PUSH_ZERO = 8'h03,
    OP_LOAD_L1   = 8'h1b,
    OP_LOAD_L2   = 8'h1c,
    OP_STORE_L1  = 8'h3c,
    OP_STORE_L2  = 8'h3d,
    OP_STORE_L3  = 8'h3e,
    OP_ADD       = 8'h60,
    OP_RETURN    = 8'hb1
  } opcode_e;

  typedef enum logic [1:0] {SRC_BYTE, SRC_ZERO, SRC_LOCAL} pushSrc_e;

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_FINISH, ST_FAULT} ctrlState_e;

  typedef struct packed {
    logic              clear;
    logic              irLoad;
    logic              pcInc;
    logic              push;
    logic              store;
    logic              add;
    pushSrc_e          src;
    logic [LIDX_W-1:0] localIdx;
  } dpStrobe_t;
endpackage

// File: rtl/sbx_datapath.sv
`timescale 1ns/1ps
module sbx_datapath
  import sbx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] opcode,
  output logic              stkFull,
  output logic              stkHasOne,
  output logic              stkHasTwo,
  input  logic [LIDX_W-1:0] dbgIdx,
  output logic [DATA_W-1:0] dbgData
);
  localparam int SP_W  = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W = $clog2(STACK_DEPTH);

  logic [ADDR_W-1:0] pcReg;
  logic [BYTE_W-1:0] irReg;
  logic [SP_W-1:0]   sp;
  logic [DATA_W-1:0] stackMem [STACK_DEPTH];
  logic [DATA_W-1:0] localReg [NUM_LOCALS];

  logic [IDX_W-1:0]  pushIdx, topIdx, belowIdx;
  logic [DATA_W-1:0] topVal, belowVal, sumVal, pushVal;

  assign pushIdx  = IDX_W'(sp);
  assign topIdx   = IDX_W'(sp - SP_W'(1));
  assign belowIdx = IDX_W'(sp - SP_W'(2));
  assign topVal   = stackMem[topIdx];
  assign belowVal = stackMem[belowIdx];
  assign sumVal   = belowVal + topVal;

  always_comb begin
    unique case (strobe.src)
      SRC_BYTE:  pushVal = {{(DATA_W-BYTE_W){memData[BYTE_W-1]}}, memData};
      SRC_LOCAL: pushVal = localReg[strobe.localIdx];
      default:   pushVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pcReg <= '0;
    else if (strobe.clear) pcReg <= '0;
    else if (strobe.pcInc) pcReg <= pcReg + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              irReg <= '0;
    else if (strobe.irLoad) irReg <= memData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          sp <= '0;
    else if (strobe.clear)              sp <= '0;
    else if (strobe.push)               sp <= sp + SP_W'(1);
    else if (strobe.store || strobe.add) sp <= sp - SP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (strobe.push)     stackMem[pushIdx]  <= pushVal;
    else if (strobe.add) stackMem[belowIdx] <= sumVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LOCALS; i++) localReg[i] <= '0;
    end else if (strobe.clear) begin
      for (int i = 0; i < NUM_LOCALS; i++) localReg[i] <= '0;
    end else if (strobe.store) begin
      localReg[strobe.localIdx] <= topVal;
    end
  end

  assign memAddr   = pcReg;
  assign opcode    = irReg;
  assign stkFull   = (sp == SP_W'(STACK_DEPTH));
  assign stkHasOne = (sp != '0);
  assign stkHasTwo = (sp >= SP_W'(2));
  assign dbgData   = localReg[dbgIdx];

  assert_sp_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    sp <= SP_W'(STACK_DEPTH));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> sp != SP_W'(STACK_DEPTH));
  assert_store_nonempty_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.store |-> sp != '0);
  assert_add_operands_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.add |-> sp >= SP_W'(2));
endmodule

// File: rtl/sbx_control.sv
`timescale 1ns/1ps
module sbx_control
  import sbx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BYTE_W-1:0] opcode,
  input  logic              stkFull,
  input  logic              stkHasOne,
  input  logic              stkHasTwo,
  output dpStrobe_t         strobe,
  output logic              done,
  output logic              error
);
  ctrlState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE, ST_FINISH, ST_FAULT: begin
        if (start) begin
          strobe.clear = 1'b1;
          stateNext    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        strobe.irLoad = 1'b1;
        strobe.pcInc  = 1'b1;
        stateNext     = ST_EXEC;
      end
      ST_EXEC: begin
        stateNext = ST_FETCH;
        case (opcode)
          OP_PUSH_BYTE: begin
            if (stkFull) stateNext = ST_FAULT;
            else begin
              strobe.push  = 1'b1;
              strobe.src   = SRC_BYTE;
              strobe.pcInc = 1'b1;
            end
          end
          OP_PUSH_ZERO: begin
            if (stkFull) stateNext = ST_FAULT;
            else begin
              strobe.push = 1'b1;
              strobe.src  = SRC_ZERO;
            end
          end
          OP_LOAD_L1, OP_LOAD_L2: begin
            if (stkFull) stateNext = ST_FAULT;
            else begin
              strobe.push     = 1'b1;
              strobe.src      = SRC_LOCAL;
              strobe.localIdx = (opcode == OP_LOAD_L1) ? LIDX_W'(1) : LIDX_W'(2);
            end
          end
          OP_STORE_L1, OP_STORE_L2, OP_STORE_L3: begin
            if (!stkHasOne) stateNext = ST_FAULT;
            else begin
              strobe.store    = 1'b1;
              strobe.localIdx = (opcode == OP_STORE_L1) ? LIDX_W'(1) :
                                (opcode == OP_STORE_L2) ? LIDX_W'(2) : LIDX_W'(3);
            end
          end
          OP_ADD: begin
            if (!stkHasTwo) stateNext = ST_FAULT;
            else            strobe.add = 1'b1;
          end
          OP_RETURN: stateNext = ST_FINISH;
          default:   stateNext = ST_FAULT;
        endcase
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign done  = (state == ST_FINISH);
  assign error = (state == ST_FAULT);

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE || state == ST_FINISH || state == ST_FAULT) && start)
      |=> state == ST_FETCH);
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);
  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (error && !start) |=> error);
endmodule

// File: rtl/sbx_top.sv
`timescale 1ns/1ps
module sbx_top
  import sbx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memData,
  output logic              done,
  output logic              error,
  input  logic [1:0]        dbgIdx,
  output logic [DATA_W-1:0] dbgData
);
  dpStrobe_t         strobe;
  logic [BYTE_W-1:0] opcode;
  logic              stkFull, stkHasOne, stkHasTwo;

  sbx_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .stkFull(stkFull), .stkHasOne(stkHasOne), .stkHasTwo(stkHasTwo),
    .strobe(strobe), .done(done), .error(error)
  );

  sbx_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memData(memData),
    .memAddr(memAddr), .opcode(opcode), .stkFull(stkFull),
    .stkHasOne(stkHasOne), .stkHasTwo(stkHasTwo),
    .dbgIdx(dbgIdx), .dbgData(dbgData)
  );
endmodule

// File: tb/sim_sbx_top.sv
`timescale 1ns/1ps
module sim_sbx_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  memAddr;
  logic [7:0]  memData;
  logic        done, error;
  logic [1:0]  dbgIdx = 2'd0;
  logic [31:0] dbgData;
  logic [7:0]  mem [256];

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  assign memData = mem[memAddr];

  sbx_top u0 (.clk(clk), .rstN(rstN), .start(start), .memAddr(memAddr),
              .memData(memData), .done(done), .error(error),
              .dbgIdx(dbgIdx), .dbgData(dbgData));

  // Behavioural reference: 0 idle, 1 fetch, 2 execute, 3 halted
  int          mState;
  logic [7:0]  mPc, mIr;
  logic [31:0] mStk [$];
  logic [31:0] mLoc [4];
  bit          mDone, mErr;

  function automatic logic [31:0] sext8(input logic [7:0] b);
    return {{24{b[7]}}, b};
  endfunction

  always @(posedge clk) begin
    logic [31:0] a, b;
    bit fault;
    if (!rstN) begin
      mState = 0; mPc = 0; mIr = 0; mStk.delete();
      foreach (mLoc[i]) mLoc[i] = 0;
      mDone = 0; mErr = 0;
    end else begin
      case (mState)
        0, 3: if (start) begin
          mState = 1; mPc = 0; mStk.delete();
          foreach (mLoc[i]) mLoc[i] = 0;
          mDone = 0; mErr = 0;
        end
        1: begin mIr = mem[mPc]; mPc = mPc + 8'd1; mState = 2; end
        default: begin
          fault = 0; mState = 1;
          case (mIr)
            8'h10: if (mStk.size() >= 8) fault = 1;
                   else begin mStk.push_back(sext8(mem[mPc])); mPc = mPc + 8'd1; end
            8'h03: if (mStk.size() >= 8) fault = 1; else mStk.push_back(0);
            8'h1b: if (mStk.size() >= 8) fault = 1; else mStk.push_back(mLoc[1]);
            8'h1c: if (mStk.size() >= 8) fault = 1; else mStk.push_back(mLoc[2]);
            8'h3c: if (mStk.size() < 1) fault = 1; else mLoc[1] = mStk.pop_back();
            8'h3d: if (mStk.size() < 1) fault = 1; else mLoc[2] = mStk.pop_back();
            8'h3e: if (mStk.size() < 1) fault = 1; else mLoc[3] = mStk.pop_back();
            8'h60: if (mStk.size() < 2) fault = 1;
                   else begin a = mStk.pop_back(); b = mStk.pop_back(); mStk.push_back(a + b); end
            8'hb1: begin mDone = 1; mState = 3; end
            default: fault = 1;
          endcase
          if (fault) begin mErr = 1; mState = 3; end
        end
      endcase
    end
  end

  // Per-cycle comparison against the reference (R12 timing, R11 debug read)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      nChecks++;
      if (done !== mDone || error !== mErr || memAddr !== mPc) begin
        nFails++;
        $display("FAIL R12 cycle compare: done/error/addr %b/%b/%h expected %b/%b/%h",
                 done, error, memAddr, mDone, mErr, mPc);
      end
      nChecks++;
      if (dbgData !== mLoc[dbgIdx]) begin
        nFails++;
        $display("FAIL R11 debug read idx %0d: actual %h expected %h",
                 dbgIdx, dbgData, mLoc[dbgIdx]);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readLocal(input int idx, output logic [31:0] v);
    dbgIdx = 2'(idx);
    #1 v = dbgData;
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic runProg(input int injectAt, input bit checkClear, output int cyc);
    logic [31:0] v;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    if (checkClear) begin
      readLocal(3, v);
      chk("R2 locals cleared by start", v, 32'd0);
    end
    cyc = 0;
    while (!(done || error) && cyc < 200) begin
      start = (cyc == injectAt);
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    if (cyc >= 200) chk("R12 run did not halt", 32'(cyc), 32'd0);
  endtask

  task automatic holdCheck(input string tag);
    logic [7:0] a;
    logic       d, e;
    a = memAddr; d = done; e = error;
    repeat (3) @(negedge clk);
    chk(tag, {22'd0, e, d, a}, {22'd0, error, done, memAddr});
  endtask

  initial begin
    int cyc;
    logic [31:0] v;
    clearMem();
    repeat (3) @(negedge clk);
    chk("R1 done after reset", {31'd0, done}, 32'd0);
    chk("R1 error after reset", {31'd0, error}, 32'd0);
    chk("R1 addr after reset", {24'd0, memAddr}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      readLocal(i, v);
      chk("R1 local zero after reset", v, 32'd0);
    end
    rstN = 1'b1;

    // x = 15, y = 9, z = x + y
    mem[0] = 8'h10; mem[1] = 8'h0f; mem[2] = 8'h3c; mem[3] = 8'h10; mem[4] = 8'h09;
    mem[5] = 8'h3d; mem[6] = 8'h03; mem[7] = 8'h3e; mem[8] = 8'h1b; mem[9] = 8'h1c;
    mem[10] = 8'h60; mem[11] = 8'h3e; mem[12] = 8'hb1;
    runProg(-1, 1'b0, cyc);
    chk("R12 done after 2N edges (N=11)", 32'(cyc), 32'd22);
    chk("R7 done raised", {30'd0, error, done}, 32'd1);
    readLocal(1, v); chk("R3 local1 = 15", v, 32'd15);
    readLocal(2, v); chk("R5 local2 = 9", v, 32'd9);
    readLocal(3, v); chk("R6 local3 = 24", v, 32'd24);
    holdCheck("R7 halted outputs hold");

    // restart clears, mid-run start ignored
    runProg(7, 1'b1, cyc);
    chk("R2 mid-run start ignored, timing", 32'(cyc), 32'd22);
    readLocal(3, v); chk("R2 mid-run start ignored, result", v, 32'd24);

    // push-zero overrides a stored value
    clearMem();
    mem[0] = 8'h10; mem[1] = 8'h07; mem[2] = 8'h3e; mem[3] = 8'h03; mem[4] = 8'h3e; mem[5] = 8'hb1;
    runProg(-1, 1'b0, cyc);
    readLocal(3, v); chk("R4 push zero stored", v, 32'd0);

    // negative byte is sign-extended
    clearMem();
    mem[0] = 8'h10; mem[1] = 8'hf6; mem[2] = 8'h10; mem[3] = 8'h05; mem[4] = 8'h60;
    mem[5] = 8'h3d; mem[6] = 8'hb1;
    runProg(-1, 1'b0, cyc);
    readLocal(2, v); chk("R3 sign-extended -10 + 5", v, 32'hffff_fffb);

    // wrap modulo 2^32
    clearMem();
    mem[0] = 8'h10; mem[1] = 8'hff; mem[2] = 8'h10; mem[3] = 8'h01; mem[4] = 8'h60;
    mem[5] = 8'h3c; mem[6] = 8'hb1;
    runProg(-1, 1'b0, cyc);
    readLocal(1, v); chk("R6 -1 + 1 wraps to 0", v, 32'd0);

    // load local twice and add
    clearMem();
    mem[0] = 8'h10; mem[1] = 8'h05; mem[2] = 8'h3c; mem[3] = 8'h1b; mem[4] = 8'h1b;
    mem[5] = 8'h60; mem[6] = 8'h3d; mem[7] = 8'hb1;
    runProg(-1, 1'b0, cyc);
    readLocal(2, v); chk("R5 local1 loaded twice and summed", v, 32'd10);

    // overflow on ninth push
    clearMem();
    for (int i = 0; i < 9; i++) mem[i] = 8'h03;
    mem[9] = 8'hb1;
    runProg(-1, 1'b0, cyc);
    chk("R8 overflow flagged", {30'd0, error, done}, 32'd2);
    chk("R8 overflow halt timing", 32'(cyc), 32'd18);
    chk("R8 addr one past faulting opcode", {24'd0, memAddr}, 32'd9);
    holdCheck("R8 halted after overflow");

    // add with one entry
    clearMem();
    mem[0] = 8'h03; mem[1] = 8'h60; mem[2] = 8'hb1;
    runProg(-1, 1'b0, cyc);
    chk("R9 add underflow flagged", {30'd0, error, done}, 32'd2);
    chk("R9 add underflow timing", 32'(cyc), 32'd4);

    // store on empty stack
    clearMem();
    mem[0] = 8'h3c; mem[1] = 8'hb1;
    runProg(-1, 1'b0, cyc);
    chk("R9 store underflow flagged", {30'd0, error, done}, 32'd2);
    readLocal(1, v); chk("R9 local1 untouched by failed store", v, 32'd0);

    // unknown opcode
    clearMem();
    mem[0] = 8'h03; mem[1] = 8'h99; mem[2] = 8'hb1;
    runProg(-1, 1'b0, cyc);
    chk("R10 unknown opcode flagged", {30'd0, error, done}, 32'd2);
    chk("R10 addr after unknown opcode", {24'd0, memAddr}, 32'd2);
    holdCheck("R10 fault holds");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule